// File: doc/BRIEF.md
# Speculative Lattice Coefficient Rejection Sampler

This block assembles a polynomial of 256 coefficients, each reduced below the 23-bit prime 8380417, from a stream of pseudo-random bytes. Every three bytes form one candidate. In the common case, four candidates arrive per beat and go straight into the coefficient buffer with no range test. This keeps the hot path free of per-candidate decisions.

The range test only starts once all 256 slots are written. The checker walks the buffer one slot per cycle. At the first slot holding an out-of-range value, a slow repair sequence begins. It moves every later coefficient one place toward index 0, one word per cycle. It then writes a fresh candidate into the top slot and resumes checking at the repaired index. Out-of-range values are rare for this modulus, so the repair path costs little on average.

A fresh candidate comes from the lanes left over in the last beat when any remain. Otherwise one new beat is taken. The finished polynomial is read through an asynchronous read port once `done` is high.

Top module: `lattice_rej_sampler`

## Requirements
- R1: After reset, `done` and `in_ready` are low. One cycle after a `start` pulse, `in_ready` is high, `done` is low and every buffer slot reads zero.
- R2: Byte k of a beat occupies `in_data[8k+7:8k]`, and earlier stream bytes sit in lower positions. Lane l uses bytes 3l, 3l+1 and 3l+2, with the earliest byte least significant. Bit 23 of each 24-bit group is discarded.
- R3: During filling, the block accepts exactly 64 beats on consecutive handshake opportunities, whatever the candidate values are, before it first lowers `in_ready`.
- R4: When `done` is high, slot i holds the i-th candidate (counted from 0) whose 23-bit value is below 8380417, in stream order.
- R5: When `done` is high, every slot is below 8380417 and bits 31:23 of every slot are zero.
- R6: Repairs take leftover lanes of the last accepted beat before they take a new beat. A run that needs E candidates beyond the first 256 therefore consumes exactly 64 + ceil(E/4) beats.
- R7: `done` rises only after the last slot has passed the range test. Once high, it stays high with `in_ready` low and the buffer unchanged until the next `start`, even if `in_valid` stays asserted.
- R8: A `start` in any state abandons the current run and clears the buffer and all counters. A beat offered in the same cycle as `start` is not consumed.
- R9: The value 8380416 is accepted, and 8380417 and 8388607 are rejected.
- R10: Consecutive out-of-range candidates are all removed. This includes runs that cover the last slot and runs among the replacement candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| start | input | 1 | One-cycle pulse that clears the buffer and begins a new polynomial |
| in_data | input | 96 | Twelve stream bytes, earliest byte in bits 7:0 |
| in_valid | input | 1 | `in_data` holds a beat |
| in_ready | output | 1 | Block accepts a beat this cycle |
| rd_addr | input | 8 | Coefficient index to read |
| rd_data | output | 32 | Coefficient at `rd_addr`, zero-extended |
| done | output | 1 | All 256 slots hold checked coefficients |

## Verification
The result is compared against a one-at-a-time rejection model for four kinds of stream.

- **Mostly random stream:** exercises plain packing and byte order.
- **Stream with hand-placed boundary values:** the exact modulus, one below it, all-ones, and values with bit 23 set. It also places runs of invalid candidates at index 0, in the middle, on the last slot and among the replacement candidates. This separates a correct shift-and-recheck from one that skips the new occupant of a repaired slot.
- **Dense stream with every fourth candidate invalid:** drives many repairs and drains the leftover lanes. The beat count then shows whether spare lanes are reused.
- **Restart and hold:** a restart in the middle of filling, and idle cycles with `in_valid` held after completion. These show that a restart discards old state and that a finished result is not disturbed.

// File: rtl/lattice_rej_sampler.sv
module lattice_rej_sampler #(
  parameter int N_COEF = 256,
  parameter int LANES = 4,
  parameter int CAND_W = 23,
  parameter int SLOT_W = 32,
  parameter logic [CAND_W-1:0] MODULUS = 23'd8380417,
  localparam int AW = $clog2(N_COEF),
  localparam int BEAT_W = LANES * 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     rd_addr,
  output logic [SLOT_W-1:0] rd_data,
  output logic              done
);

  localparam logic [AW-1:0] LAST = AW'(N_COEF - 1);
  localparam logic [AW-1:0] FILL_LAST = AW'(N_COEF - LANES);
  localparam int PW = $clog2(LANES);

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_CHECK, S_SHIFT, S_REFILL, S_DONE} st_t;

  st_t               st;
  logic [SLOT_W-1:0] mem [N_COEF];
  logic [AW-1:0]     wr_idx, chk_idx, sh_ptr;
  logic [CAND_W-1:0] pend [LANES-1];
  logic [PW-1:0]     pend_cnt;
  logic [CAND_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = in_data[24*g +: CAND_W];
  end

  assign in_ready = (st == S_FILL) || (st == S_REFILL && pend_cnt == '0);
  assign done     = (st == S_DONE);
  assign rd_data  = mem[rd_addr];

  wire              beat_ok  = in_valid & in_ready;
  wire              chk_bad  = mem[chk_idx] >= SLOT_W'(MODULUS);
  wire [SLOT_W-1:0] nxt_word = mem[sh_ptr + 1'b1];

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      st       <= rst_n ? S_FILL : S_IDLE;
      wr_idx   <= '0;
      chk_idx  <= '0;
      sh_ptr   <= '0;
      pend_cnt <= '0;
      for (int i = 0; i < N_COEF; i++) mem[i] <= '0;
      for (int i = 0; i < LANES - 1; i++) pend[i] <= '0;
    end else begin
      case (st)
        S_FILL: if (beat_ok) begin
          for (int l = 0; l < LANES; l++) mem[wr_idx + AW'(l)] <= SLOT_W'(lane[l]);
          wr_idx <= wr_idx + AW'(LANES);
          if (wr_idx == FILL_LAST) begin
            st      <= S_CHECK;
            chk_idx <= '0;
          end
        end
        S_CHECK:
          if (chk_bad) begin
            sh_ptr <= chk_idx;
            st     <= S_SHIFT;
          end else if (chk_idx == LAST) begin
            st <= S_DONE;
          end else begin
            chk_idx <= chk_idx + 1'b1;
          end
        S_SHIFT:
          if (sh_ptr == LAST) begin
            st <= S_REFILL;
          end else begin
            mem[sh_ptr] <= nxt_word;
            sh_ptr      <= sh_ptr + 1'b1;
          end
        S_REFILL:
          if (pend_cnt != '0) begin
            mem[LAST] <= SLOT_W'(pend[0]);
            for (int i = 0; i < LANES - 2; i++) pend[i] <= pend[i+1];
            pend_cnt <= pend_cnt - 1'b1;
            st       <= S_CHECK;
          end else if (in_valid) begin
            mem[LAST] <= SLOT_W'(lane[0]);
            for (int i = 0; i < LANES - 1; i++) pend[i] <= lane[i+1];
            pend_cnt <= PW'(LANES - 1);
            st       <= S_CHECK;
          end
        default: ;
      endcase
    end
  end

  // R3
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && beat_ok && !start && wr_idx != FILL_LAST) |=>
      (st == S_FILL && wr_idx == $past(wr_idx) + AW'(LANES)));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R7
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st == S_CHECK && chk_idx == LAST));

  // R5
  done_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem[LAST] < SLOT_W'(MODULUS) && mem[0] < SLOT_W'(MODULUS)));

  // R10
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && sh_ptr != LAST && !start) |=>
      (mem[sh_ptr - 1'b1] == $past(nxt_word)));

endmodule

// File: tb/lattice_rej_sampler_test.sv
`timescale 1ns/1ps
module lattice_rej_sampler_test;

  localparam int N = 256;
  localparam int LANES = 4;
  localparam int NCAND = 1024;
  localparam logic [22:0] Q = 23'd8380417;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [95:0] in_data = '0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        done;

  int checks = 0;
  int errors = 0;

  logic [23:0] cand [NCAND];
  logic [31:0] expv [N];
  int          exp_beats;
  int unsigned seed = 32'h1badcafe;

  always #2.5 clk = ~clk;

  lattice_rej_sampler uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expd);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expd);
    end
  endtask

  function automatic logic [23:0] rnd24();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed[23:0];
  endfunction

  task automatic fill_random();
    for (int i = 0; i < NCAND; i++) cand[i] = rnd24();
  endtask

  task automatic build_ref();
    int k = 0;
    int used = 0;
    for (int i = 0; i < NCAND && k < N; i++) begin
      if (cand[i][22:0] < Q) begin
        expv[k] = {9'd0, cand[i][22:0]};
        k++;
        used = i + 1;
      end
    end
    exp_beats = 64 + (used - 256 + 3) / 4;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_stream(input string name, input bit do_start);
    int  b = 0;
    int  fast = 0;
    int  cyc = 0;
    bit  in_fast = 1;
    bit  hs;
    build_ref();
    if (do_start) pulse_start();
    while (!done && cyc < 100000) begin
      for (int l = 0; l < LANES; l++) in_data[24*l +: 24] = cand[4*b + l];
      in_valid = 1;
      hs = in_ready;
      if (in_fast) begin
        if (hs) fast++;
        else in_fast = 0;
      end
      @(posedge clk);
      @(negedge clk);
      if (hs) b++;
      cyc++;
    end
    in_valid = 0;
    check(done == 1, "R7", {name, " done reached"}, done, 1);
    check(fast == 64, "R3", {name, " beats before first stall"}, fast, 64);
    check(b == exp_beats, "R6", {name, " beats consumed"}, b, exp_beats);
  endtask

  task automatic compare_poly(input string name);
    int bad = 0;
    int first = -1;
    int range_bad = 0;
    logic [31:0] act_first = '0;
    for (int a = 0; a < N; a++) begin
      rd_addr = a[7:0];
      #0.1;
      if (rd_data !== expv[a]) begin
        if (first < 0) begin
          first = a;
          act_first = rd_data;
        end
        bad++;
      end
      if (rd_data[31:23] != 0 || rd_data[22:0] >= Q) range_bad++;
    end
    check(bad == 0, "R4", $sformatf("%s slot %0d", name, first), act_first,
          first < 0 ? 0 : expv[first]);
    check(range_bad == 0, "R5", {name, " out-of-range slots"}, range_bad, 0);
  endtask

  task automatic read_slot(input int a, output logic [31:0] v);
    rd_addr = a[7:0];
    #0.1;
    v = rd_data;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done == 0, "R1", "done after reset", done, 0);
    check(in_ready == 0, "R1", "in_ready after reset", in_ready, 0);
  endtask

  task automatic t_random();
    fill_random();
    run_stream("random", 1);
    compare_poly("random");
  endtask

  task automatic t_forced();
    logic [31:0] v;
    fill_random();
    for (int i = 0; i < NCAND; i++) cand[i][22:0] = cand[i][22:0] % Q;
    cand[0] = 24'h800005;
    cand[1] = {1'b0, Q};
    cand[2] = {1'b0, Q + 23'd1};
    cand[3] = 24'h7fffff;
    cand[4] = {1'b0, Q - 23'd1};
    cand[100] = 24'hffffff;
    for (int i = 200; i < 206; i++) cand[i] = {1'b0, Q + 23'(i)};
    cand[255] = {1'b0, Q};
    cand[256] = 24'h7ffffe;
    cand[257] = 24'hffffff;
    cand[258] = {1'b1, Q};
    cand[259] = 24'h800000;
    run_stream("forced", 1);
    compare_poly("forced");
    read_slot(0, v);
    check(v == 5, "R2", "bit 23 dropped, little-endian slot 0", v, 5);
    read_slot(1, v);
    check(v == {9'd0, Q - 23'd1}, "R9", "q-1 kept after run of rejects", v, Q - 1);
    read_slot(N - 1, v);
    check(v == expv[N-1], "R10", "last slot after refill run", v, expv[N-1]);
  endtask

  task automatic t_dense();
    fill_random();
    for (int i = 0; i < NCAND; i++)
      cand[i][22:0] = (i % 4 == 3) ? Q + 23'(i % 8000) : cand[i][22:0] % Q;
    run_stream("dense", 1);
    compare_poly("dense");
  endtask

  task automatic t_restart();
    logic [31:0] v0, v1;
    fill_random();
    pulse_start();
    for (int b = 0; b < 10; b++) begin
      in_data = {cand[4*b+3], cand[4*b+2], cand[4*b+1], cand[4*b]};
      in_valid = 1;
      @(negedge clk);
    end
    in_data = ~in_data;
    start = 1;
    @(negedge clk);
    start = 0;
    in_valid = 0;
    read_slot(0, v0);
    read_slot(39, v1);
    check(v0 == 0 && v1 == 0, "R8", "buffer cleared by restart", v0 | v1, 0);
    check(in_ready == 1 && done == 0, "R1", "ready after start", in_ready, 1);
    run_stream("restart", 0);
    compare_poly("restart");
  endtask

  task automatic t_hold();
    logic [31:0] v;
    int stray = 0;
    in_data = {96{1'b1}};
    in_valid = 1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (in_ready || !done) stray++;
    end
    in_valid = 0;
    check(stray == 0, "R7", "idle after done", stray, 0);
    read_slot(N - 1, v);
    check(v == expv[N-1], "R7", "buffer unchanged after done", v, expv[N-1]);
    compare_poly("hold");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL all: watchdog expired, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_random();
    t_forced();
    t_hold();
    t_dense();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule